// File: doc/BRIEF.md
# Power Mode and Wake-Up Controller

This block decides which power state a small microcontroller is in and turns that state into clock-enable outputs for the CPU and for the peripherals. It has five states. In full-speed run, both domains are enabled. In wait-for-interrupt, the CPU is held and the peripherals keep running until an interrupt is acknowledged. In stop, everything is gated and the controller waits for a wake-up. There is also a stabilization phase after stop. Halt is frozen until reset. A reduced-clock option works in run and in wait-for-interrupt. It thins the enables with a prescaler, so combining it with wait-for-interrupt gives the low-power wait state.

Stop can only be requested by a fixed three-write pattern on a stop-control bit, and only while the non-maskable interrupt pin is low. While stopped, the controller watches a bank of wake-up lines, each with its own enable bit, plus the non-maskable interrupt pin. It records which source woke it. It then waits for an oscillator-ready indication and counts a stabilization interval before it releases the clocks. Entering stop drops any PLL clock selection, so software must reselect it. Holding the watchdog counter frozen is signalled through a run output.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (run), cpu_clk_en_o, per_clk_en_o, wdog_run_o and clk_ready_o are 1, and pll_sel_o and wake_src_o are 0. The mode_o codes are 0 run, 1 wait, 2 stop, 3 stabilize and 4 halt.
- R2: In run, a wfi_req_i pulse moves mode_o to 1 at the next clock edge. There cpu_clk_en_o is 0 while per_clk_en_o stays enabled. An irq_ack_i pulse returns mode_o to 0.
- R3: With slow_en_i high, the enables in run and wait are high on one cycle in every SLOW_DIV cycles. In wait with slow_en_i high, per_clk_en_o pulses while cpu_clk_en_o stays 0.
- R4: In run, three consecutive stop writes (stop_wr_i high) carrying stop_wdata_i values 1, 0, 1 move mode_o to 2 on the edge of the third write, provided nmi_i is low at that edge. Cycles without a write between them are allowed.
- R5: A stop write whose value breaks the 1, 0, 1 pattern restarts the pattern and mode_o stays 0. A completed pattern while nmi_i is high leaves mode_o at 0 and restarts the pattern.
- R6: In modes 2 and 3, cpu_clk_en_o, per_clk_en_o, wdog_run_o and clk_ready_o are all 0.
- R7: In mode 2, a rising edge on a wake_i line whose wake_mask_i bit is 1, or a rising edge on nmi_i, moves mode_o to 3. wake_src_o then holds the lowest risen enabled line index, or N_WAKE when only nmi_i rose. A rising edge on a masked line has no effect.
- R8: In mode 3, the stabilization count advances only on cycles with osc_ready_i high. After STAB_CYC such cycles, mode_o returns to 0 and clk_ready_o rises.
- R9: A pll_set_i pulse in run sets pll_sel_o. Entering stop clears it, and it stays 0 after returning to run.
- R10: In run, halt_req_i with wdog_en_i low moves mode_o to 4, where all enables are 0 and no input except reset changes mode_o. With wdog_en_i high, halt_req_i is ignored.
- R11: wdog_run_o is 1 exactly in modes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_en_i | input | 1 | Reduced-clock option |
| wfi_req_i | input | 1 | Wait-for-interrupt request pulse |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| halt_req_i | input | 1 | Halt request pulse |
| wdog_en_i | input | 1 | Watchdog enabled |
| stop_wr_i | input | 1 | Write strobe to stop-control bit |
| stop_wdata_i | input | 1 | Value written to stop-control bit |
| pll_set_i | input | 1 | Select PLL clock pulse |
| nmi_i | input | 1 | Non-maskable interrupt pin |
| wake_i | input | N_WAKE | Wake-up lines |
| wake_mask_i | input | N_WAKE | Per-line wake enable |
| osc_ready_i | input | 1 | Oscillator running indication |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| wdog_run_o | output | 1 | Watchdog count enable |
| clk_ready_o | output | 1 | Clocks stabilized |
| pll_sel_o | output | 1 | PLL clock selected |
| mode_o | output | 3 | Current mode code |
| wake_src_o | output | $clog2(N_WAKE+1) | Index of last wake-up source |

## Verification
The bench builds the controller with N_WAKE=16, SLOW_DIV=4 and STAB_CYC=5. The short divider lets the one-in-four pulse pattern of the reduced clock be counted within a few cycles. The five-cycle stabilization window can be timed exactly, both with the oscillator-ready input held and with it withheld. All sixteen lines keep their full width, so the top line index (15) and the non-maskable code (16) are both reached by wake-up cases.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    PM_RUN  = 3'd0,
    PM_WFI  = 3'd1,
    PM_STOP = 3'd2,
    PM_STAB = 3'd3,
    PM_HALT = 3'd4
  } pm_state_e;
endpackage

// File: rtl/pwr_prescaler.sv
module pwr_prescaler #(
  parameter int DIV = 8,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [CW-1:0] cnt_q, cnt_nx;

  always_comb begin
    if (cnt_q == CW'(DIV - 1)) cnt_nx = '0;
    else                       cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nx;
  end

  assign tick_o = (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/pwr_stop_seq.sv
module pwr_stop_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic done_o
);
  logic [1:0] stage_q, stage_nx;

  always_comb begin
    stage_nx = stage_q;
    if (!en_i) begin
      stage_nx = 2'd0;
    end else if (wr_i) begin
      unique case (stage_q)
        2'd0:    stage_nx = wdata_i ? 2'd1 : 2'd0;
        2'd1:    stage_nx = wdata_i ? 2'd0 : 2'd2;
        default: stage_nx = 2'd0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'd0;
    else         stage_q <= stage_nx;
  end

  assign done_o = en_i && wr_i && wdata_i && (stage_q == 2'd2);
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int N_WAKE = 16,
  localparam int IW = $clog2(N_WAKE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_WAKE-1:0] lines_i,
  input  logic [N_WAKE-1:0] mask_i,
  input  logic              nmi_i,
  output logic              hit_o,
  output logic [IW-1:0]     idx_o
);
  logic [N_WAKE-1:0] prev_q, rise;
  logic              nmi_prev_q, nmi_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      nmi_prev_q <= 1'b0;
    end else begin
      prev_q     <= lines_i;
      nmi_prev_q <= nmi_i;
    end
  end

  assign rise     = lines_i & ~prev_q & mask_i;
  assign nmi_rise = nmi_i & ~nmi_prev_q;
  assign hit_o    = (|rise) | nmi_rise;

  always_comb begin
    idx_o = IW'(N_WAKE);
    for (int i = N_WAKE - 1; i >= 0; i--) begin
      if (rise[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/pwr_stab_timer.sv
module pwr_stab_timer #(
  parameter int CYC = 1024,
  localparam int SW = (CYC > 1) ? $clog2(CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);
  logic [SW-1:0] cnt_q, cnt_nx;
  logic          last;

  assign last = (cnt_q == SW'(CYC - 1));

  always_comb begin
    cnt_nx = cnt_q;
    if (clear_i)           cnt_nx = '0;
    else if (run_i && !last) cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nx;
  end

  assign done_o = run_i && last;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int N_WAKE   = 16,
  parameter int SLOW_DIV = 8,
  parameter int STAB_CYC = 1024,
  localparam int SRC_W   = $clog2(N_WAKE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_en_i,
  input  logic              wfi_req_i,
  input  logic              irq_ack_i,
  input  logic              halt_req_i,
  input  logic              wdog_en_i,
  input  logic              stop_wr_i,
  input  logic              stop_wdata_i,
  input  logic              pll_set_i,
  input  logic              nmi_i,
  input  logic [N_WAKE-1:0] wake_i,
  input  logic [N_WAKE-1:0] wake_mask_i,
  input  logic              osc_ready_i,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              wdog_run_o,
  output logic              clk_ready_o,
  output logic              pll_sel_o,
  output logic [2:0]        mode_o,
  output logic [SRC_W-1:0]  wake_src_o
);
  pm_state_e          state_q, state_nx;
  logic               pll_q, pll_nx;
  logic [SRC_W-1:0]   src_q, src_nx;
  logic               slow_tick, seq_done, wake_hit, stab_done;
  logic [SRC_W-1:0]   wake_idx;
  logic               in_run, in_wfi, in_stop, in_stab, gate_tick;

  assign in_run  = (state_q == PM_RUN);
  assign in_wfi  = (state_q == PM_WFI);
  assign in_stop = (state_q == PM_STOP);
  assign in_stab = (state_q == PM_STAB);

  pwr_prescaler #(.DIV(SLOW_DIV)) presc_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(slow_tick));

  pwr_stop_seq seq_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(in_run),
    .wr_i(stop_wr_i), .wdata_i(stop_wdata_i), .done_o(seq_done));

  pwr_wake_detect #(.N_WAKE(N_WAKE)) wake_det_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .lines_i(wake_i), .mask_i(wake_mask_i),
    .nmi_i(nmi_i), .hit_o(wake_hit), .idx_o(wake_idx));

  pwr_stab_timer #(.CYC(STAB_CYC)) stab_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(in_stop),
    .run_i(in_stab && osc_ready_i), .done_o(stab_done));

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      PM_RUN: begin
        if (seq_done && !nmi_i)             state_nx = PM_STOP;
        else if (halt_req_i && !wdog_en_i)  state_nx = PM_HALT;
        else if (wfi_req_i)                 state_nx = PM_WFI;
      end
      PM_WFI:  if (irq_ack_i) state_nx = PM_RUN;
      PM_STOP: if (wake_hit)  state_nx = PM_STAB;
      PM_STAB: if (stab_done) state_nx = PM_RUN;
      PM_HALT: state_nx = PM_HALT;
      default: state_nx = PM_RUN;
    endcase
  end

  always_comb begin
    pll_nx = pll_q;
    if (in_run && state_nx == PM_STOP) pll_nx = 1'b0;
    else if (in_run && pll_set_i)      pll_nx = 1'b1;
    src_nx = src_q;
    if (in_stop && wake_hit) src_nx = wake_idx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PM_RUN;
      pll_q   <= 1'b0;
      src_q   <= '0;
    end else begin
      state_q <= state_nx;
      pll_q   <= pll_nx;
      src_q   <= src_nx;
    end
  end

  assign gate_tick    = slow_en_i ? slow_tick : 1'b1;
  assign cpu_clk_en_o = in_run && gate_tick;
  assign per_clk_en_o = (in_run || in_wfi) && gate_tick;
  assign wdog_run_o   = in_run || in_wfi;
  assign clk_ready_o  = !(in_stop || in_stab);
  assign pll_sel_o    = pll_q;
  assign mode_o       = state_q;
  assign wake_src_o   = src_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       nmi_i,
  input logic       wdog_en_i,
  input logic       cpu_clk_en_o,
  input logic       per_clk_en_o,
  input logic       wdog_run_o,
  input logic       clk_ready_o,
  input logic       pll_sel_o,
  input logic [2:0] mode_o
);
  // R2: CPU held in wait
  p_wfi_cpu_held_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd1) |-> !cpu_clk_en_o);

  // R4: stop entered only with nmi low
  p_stop_nmi_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2 && $past(mode_o) == 3'd0) |-> !$past(nmi_i));

  // R6: everything gated in stop and stabilize
  p_stop_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2 || mode_o == 3'd3) |->
      (!cpu_clk_en_o && !per_clk_en_o && !wdog_run_o && !clk_ready_o));

  // R9: PLL selection dropped while stopped
  p_pll_dropped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2) |-> !pll_sel_o);

  // R10: halt is sticky
  p_halt_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4) |=> (mode_o == 3'd4));

  // R10: halt only with watchdog off
  p_halt_wdog_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4 && $past(mode_o) == 3'd0) |-> !$past(wdog_en_i));

  // R8: stabilize leaves only to run
  p_stab_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3) |=> (mode_o == 3'd3 || mode_o == 3'd0));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .nmi_i(nmi_i), .wdog_en_i(wdog_en_i),
  .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o),
  .wdog_run_o(wdog_run_o), .clk_ready_o(clk_ready_o),
  .pll_sel_o(pll_sel_o), .mode_o(mode_o));

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW   = 16;
  localparam int DIV  = 4;
  localparam int STAB = 5;
  localparam int SW   = $clog2(NW + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic slow_en, wfi_req, irq_ack, halt_req, wdog_en, stop_wr, stop_wdata;
  logic pll_set, nmi, osc_ready;
  logic [NW-1:0] wake, wake_mask;
  logic cpu_en, per_en, wdog_run, clk_ready, pll_sel;
  logic [2:0] mode;
  logic [SW-1:0] wake_src;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.N_WAKE(NW), .SLOW_DIV(DIV), .STAB_CYC(STAB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .slow_en_i(slow_en), .wfi_req_i(wfi_req),
    .irq_ack_i(irq_ack), .halt_req_i(halt_req), .wdog_en_i(wdog_en),
    .stop_wr_i(stop_wr), .stop_wdata_i(stop_wdata), .pll_set_i(pll_set),
    .nmi_i(nmi), .wake_i(wake), .wake_mask_i(wake_mask),
    .osc_ready_i(osc_ready), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
    .wdog_run_o(wdog_run), .clk_ready_o(clk_ready), .pll_sel_o(pll_sel),
    .mode_o(mode), .wake_src_o(wake_src));

  // mask, lines, nmi rise, expected source index
  typedef struct packed {
    logic [NW-1:0] mask;
    logic [NW-1:0] lines;
    logic          nmi;
    logic [7:0]    idx;
  } wake_vec_t;
  localparam wake_vec_t VEC [4] = '{
    '{16'hFFFF, 16'h0008, 1'b0, 8'd3},
    '{16'h00F0, 16'h0091, 1'b0, 8'd4},
    '{16'hFFFF, 16'h8000, 1'b0, 8'd15},
    '{16'h0000, 16'h0003, 1'b1, 8'd16}
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic stop_write(logic v);
    stop_wr = 1'b1; stop_wdata = v;
    @(negedge clk);
    stop_wr = 1'b0; stop_wdata = 1'b0;
  endtask

  task automatic enter_stop();
    stop_write(1'b1); stop_write(1'b0); stop_write(1'b1);
  endtask

  task automatic count_en(int n, output int c_cpu, output int c_per);
    c_cpu = 0; c_per = 0;
    for (int i = 0; i < n; i++) begin
      c_cpu += int'(cpu_en); c_per += int'(per_en);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int cc, cp;
    slow_en = 0; wfi_req = 0; irq_ack = 0; halt_req = 0; wdog_en = 0;
    stop_wr = 0; stop_wdata = 0; pll_set = 0; nmi = 0; osc_ready = 1;
    wake = '0; wake_mask = '0;
    @(negedge clk);
    do_reset();

    // R1 reset state
    check("R1 mode", mode, 0);
    check("R1 cpu_en", cpu_en, 1);
    check("R1 per_en", per_en, 1);
    check("R1 clk_ready", clk_ready, 1);
    check("R1 pll_sel", pll_sel, 0);
    check("R1 wake_src", wake_src, 0);
    check("R11 wdog_run in run", wdog_run, 1);

    // R2 wait for interrupt
    pulse(wfi_req);
    check("R2 mode wait", mode, 1);
    check("R2 cpu held", cpu_en, 0);
    check("R2 per running", per_en, 1);
    check("R11 wdog_run in wait", wdog_run, 1);
    pulse(irq_ack);
    check("R2 back to run", mode, 0);

    // R3 reduced clock
    slow_en = 1;
    count_en(8, cc, cp);
    check("R3 cpu pulses slow run", cc, 8 / DIV);
    pulse(wfi_req);
    count_en(8, cc, cp);
    check("R3 cpu in slow wait", cc, 0);
    check("R3 per pulses slow wait", cp, 8 / DIV);
    pulse(irq_ack);
    slow_en = 0;

    // R9 PLL selection
    pulse(pll_set);
    check("R9 pll set", pll_sel, 1);

    // R5 broken pattern 1,0,0
    stop_write(1'b1); stop_write(1'b0); stop_write(1'b0);
    check("R5 abort stays run", mode, 0);
    // R5 complete pattern with nmi high
    stop_write(1'b1); stop_write(1'b0);
    nmi = 1;
    stop_write(1'b1);
    check("R5 nmi high stays run", mode, 0);
    check("R5 pll untouched", pll_sel, 1);
    nmi = 0;
    @(negedge clk);

    // R4 / R6 / R9 stop entry
    enter_stop();
    check("R4 stop entered", mode, 2);
    check("R6 cpu off", cpu_en, 0);
    check("R6 per off", per_en, 0);
    check("R6 wdog frozen", wdog_run, 0);
    check("R6 clk not ready", clk_ready, 0);
    check("R9 pll cleared", pll_sel, 0);

    // R7 masked line ignored
    wake_mask = 16'hFF00;
    wake = 16'h0001;
    repeat (2) @(negedge clk);
    check("R7 masked line ignored", mode, 2);
    wake = '0;
    @(negedge clk);

    // R8 oscillator not ready holds the count
    osc_ready = 0;
    wake = 16'h0100;
    @(negedge clk);
    check("R7 wake to stabilize", mode, 3);
    check("R7 source 8", wake_src, 8);
    wake = '0;
    repeat (10) @(negedge clk);
    check("R8 held without osc", mode, 3);
    check("R8 clk not ready", clk_ready, 0);
    osc_ready = 1;
    repeat (STAB - 1) @(negedge clk);
    check("R8 still stabilizing", mode, 3);
    @(negedge clk);
    check("R8 released to run", mode, 0);
    check("R8 clk ready", clk_ready, 1);
    check("R9 pll stays cleared", pll_sel, 0);

    // R7 / R8 vector table
    for (int k = 0; k < 4; k++) begin
      enter_stop();
      check("R4 stop entered (vec)", mode, 2);
      wake_mask = VEC[k].mask;
      wake = VEC[k].lines;
      nmi  = VEC[k].nmi;
      @(negedge clk);
      check("R7 vec stabilize", mode, 3);
      check("R7 vec source", wake_src, int'(VEC[k].idx));
      wake = '0; nmi = 0;
      repeat (STAB - 1) @(negedge clk);
      check("R8 vec count", mode, 3);
      @(negedge clk);
      check("R8 vec run", mode, 0);
    end

    // R10 halt ignored with watchdog on
    wdog_en = 1;
    pulse(halt_req);
    check("R10 halt ignored", mode, 0);
    wdog_en = 0;
    pulse(halt_req);
    check("R10 halt entered", mode, 4);
    check("R10 cpu off", cpu_en, 0);
    check("R10 per off", per_en, 0);
    check("R11 wdog_run in halt", wdog_run, 0);
    pulse(irq_ack);
    wake_mask = '1; wake = 16'h0002; nmi = 1;
    repeat (3) @(negedge clk);
    wake = '0; nmi = 0;
    check("R10 halt sticky", mode, 4);
    do_reset();
    check("R10 reset leaves halt", mode, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule